// File: doc/BRIEF.md
# Scatter-Gather Receive Packet Splitter

This block is the receive side of a descriptor-driven DMA engine. Bytes arrive on a valid/ready stream that carries a last flag. The block stores them into memory buffers that a ring of descriptors describes. Each descriptor gives a buffer address and a capacity. When a buffer fills before the packet ends, the rest of the packet continues in the next descriptor's buffer. When a buffer is closed, either because it is full or because the packet ended, the block writes a status word back into that descriptor. The status word holds the byte count and marks whether the buffer holds the first and/or the last bytes of a packet.

Software controls the block with a run/stop level, an interrupt enable, a current-pointer load and a tail-pointer load. It observes a halted flag, an idle flag and a completion interrupt. Descriptor words are read and written through one 32-bit port with one-cycle read latency. Packet bytes leave through a separate byte-wide write port. The engine keeps one descriptor fetched ahead of the buffer it is filling.

Top module: `rxsg_splitter`

## Requirements
- R1: The status written back for the descriptor that receives the first byte of a packet has its start-of-packet bit (bit 27) set. Every other descriptor has this bit clear.
- R2: When a buffer reaches its capacity before the packet's last byte, the following bytes go into the next descriptor's buffer. This continues across as many descriptors as needed, including after software moves the tail forward while a packet is stalled.
- R3: The status of the descriptor holding a packet's last byte has its end-of-packet bit (bit 26) set, and that descriptor is closed. The next packet starts in a fresh descriptor.
- R4: The status word has bit 31 set as a completion mark. Its low CNT_W bits give the number of bytes actually stored in that buffer, which may be less than the capacity.
- R5: A packet that starts and ends inside one buffer leaves both bit 27 and bit 26 set in that descriptor's status.
- R6: While the next descriptor is already fetched, a buffer change in the middle of a gapless packet costs no cycle with stream ready low, for buffers of capacity 8 or more.
- R7: After reset, halted is 1, stream ready is 0 and no descriptor is read. One cycle after run/stop rises, halted reads 0. A tail-pointer load while run/stop is 0 is ignored. The first descriptor reads begin only after a tail load while run/stop is 1.
- R8: When the descriptor at the tail has been filled and the packet has not ended, stream ready stays 0 and the idle flag is 1.
- R9: The completion interrupt pulses one cycle after the write-back of a status word that has bit 26 set, and only while the interrupt enable is 1. No interrupt follows a buffer closed without bit 26.
- R10: Bytes are written in arrival order to consecutive byte addresses, starting at the descriptor's buffer address.
- R11: A descriptor is four 32-bit words: next-descriptor pointer at offset 0, buffer address at offset 4, capacity in the low CNT_W bits at offset 8, and status at offset 12. Each fetch reads offsets 0, 4 and 8, and the write-back writes only offset 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runStop | input | 1 | 1 runs the channel, 0 stops it |
| doneIrqEn | input | 1 | Enables the packet-complete interrupt |
| curPtrWr | input | 1 | Loads ptrData as the first descriptor to fetch (taken only while halted) |
| tailPtrWr | input | 1 | Loads ptrData as the tail descriptor and arms fetching |
| ptrData | input | ADDR_W | Pointer value for the two loads |
| halted | output | 1 | Channel is stopped |
| idle | output | 1 | Descriptors up to the tail are used up |
| irqDone | output | 1 | One-cycle packet-complete interrupt |
| sValid | input | 1 | Stream byte valid |
| sReady | output | 1 | Stream byte accepted when high with sValid |
| sData | input | 8 | Stream byte |
| sLast | input | 1 | Byte is the last of its packet |
| descReq | output | 1 | Descriptor port access this cycle |
| descWe | output | 1 | Access is a write (status write-back) |
| descAddr | output | ADDR_W | Byte address of the descriptor word |
| descWdata | output | 32 | Status word to write |
| descRdata | input | 32 | Read data, valid the cycle after a read |
| dataWe | output | 1 | Byte write strobe |
| dataAddr | output | ADDR_W | Byte address in the buffer |
| dataByte | output | 8 | Byte to write |

## Verification
Two actions contend for the single descriptor port: the status write-back of a buffer just closed, and the three reads that prefetch the following descriptor. Both can be due in the same cycle. The bench provokes this with random capacities as small as one byte and random gaps in the stream, so buffers close while a prefetch is in flight. It judges the outcome by comparing every status word and every stored byte against a model computed in the bench from the capacities and packet lengths. A write-back that is lost, delayed onto the wrong descriptor, or merged with another shows up as a status mismatch.

// File: rtl/rxsg_pkg.sv
package rxsg_pkg;

  // descriptor word offsets (bytes)
  localparam int OFF_NEXT = 0;
  localparam int OFF_BUF  = 4;
  localparam int OFF_CAP  = 8;
  localparam int OFF_STAT = 12;

  // status word bit positions
  localparam int STAT_DONE_BIT = 31;
  localparam int STAT_SOF_BIT  = 27;
  localparam int STAT_EOF_BIT  = 26;

  // strobes from control to datapath
  typedef struct packed {
    logic       fetchStart;
    logic       fetchIssue;
    logic [1:0] fetchWord;
    logic       capWord;
    logic [1:0] capIdx;
    logic       fetchDone;
    logic       wbFire;
    logic       accept;
    logic       markSof;
    logic       loadCur;
    logic       loadTail;
  } ctrlStrobe_t;

  // state reported by datapath to control
  typedef struct packed {
    logic actValid;
    logic nxtValid;
    logic wbPending;
    logic stgIsTail;
  } dpStatus_t;

endpackage

// File: rtl/rxsg_ctrl.sv
module rxsg_ctrl
  import rxsg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        runStop,
  input  logic        curPtrWr,
  input  logic        tailPtrWr,
  input  logic        sValid,
  input  logic        sLast,
  input  dpStatus_t   st,
  output ctrlStrobe_t stb,
  output logic        halted,
  output logic        idle,
  output logic        sReady
);

  logic       haltedQ;
  logic       fetchEn;
  logic       chainDone;
  logic       fetchBusy;
  logic [1:0] fetchCnt;
  logic       inPacket;
  logic       running;
  logic       wbFire;
  logic       readyInt;

  assign running  = !haltedQ;
  // write-back may use the port unless a prefetch read is being issued
  assign wbFire   = st.wbPending && (!fetchBusy || fetchCnt == 2'd3);
  assign readyInt = running && st.actValid && (!st.wbPending || wbFire);

  always_comb begin
    stb            = '0;
    stb.wbFire     = wbFire;
    stb.accept     = readyInt && sValid;
    stb.markSof    = readyInt && sValid && !inPacket;
    stb.loadCur    = curPtrWr && haltedQ;
    stb.loadTail   = tailPtrWr && runStop;
    stb.fetchStart = running && fetchEn && !chainDone && !fetchBusy &&
                     !st.nxtValid && !st.wbPending;
    stb.fetchIssue = fetchBusy && fetchCnt != 2'd3;
    stb.fetchWord  = fetchCnt;
    stb.capWord    = fetchBusy && fetchCnt != 2'd0;
    stb.capIdx     = fetchCnt - 2'd1;
    stb.fetchDone  = fetchBusy && fetchCnt == 2'd3;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haltedQ   <= 1'b1;
      fetchEn   <= 1'b0;
      chainDone <= 1'b0;
      fetchBusy <= 1'b0;
      fetchCnt  <= 2'd0;
      inPacket  <= 1'b0;
    end else begin
      haltedQ <= !runStop;
      if (stb.loadTail) fetchEn <= 1'b1;
      if (stb.loadTail)
        chainDone <= 1'b0;
      else if (stb.fetchDone && st.stgIsTail)
        chainDone <= 1'b1;
      if (stb.fetchStart) begin
        fetchBusy <= 1'b1;
        fetchCnt  <= 2'd0;
      end else if (fetchBusy) begin
        fetchCnt <= fetchCnt + 2'd1;
        if (fetchCnt == 2'd3) fetchBusy <= 1'b0;
      end
      if (stb.accept) inPacket <= !sLast;
    end
  end

  assign halted = haltedQ;
  assign sReady = readyInt;
  assign idle   = running && fetchEn && chainDone && !st.actValid &&
                  !st.nxtValid && !fetchBusy;

  assert_halt_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runStop) |=> !halted);

  assert_idle_blocks_stream_R8: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> !sReady);

endmodule

// File: rtl/rxsg_datapath.sv
module rxsg_datapath
  import rxsg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [ADDR_W-1:0] ptrData,
  input  logic              irqEn,
  input  logic [7:0]        sData,
  input  logic              sLast,
  input  logic [31:0]       descRdata,
  output dpStatus_t         st,
  output logic              descReq,
  output logic              descWe,
  output logic [ADDR_W-1:0] descAddr,
  output logic [31:0]       descWdata,
  output logic              dataWe,
  output logic [ADDR_W-1:0] dataAddr,
  output logic [7:0]        dataByte,
  output logic              irqDone
);

  typedef struct packed {
    logic              valid;
    logic [ADDR_W-1:0] desc;
    logic [ADDR_W-1:0] bufBase;
    logic [CNT_W-1:0]  cap;
    logic [CNT_W-1:0]  cnt;
    logic              sof;
  } slot_t;

  slot_t             act, nxt, fetched;
  logic [ADDR_W-1:0] fetchPtr, tailPtr;
  logic [ADDR_W-1:0] stgDesc, stgNext, stgBuf;
  logic              wbPending, wbIrq, irqQ;
  logic [ADDR_W-1:0] wbAddr;
  logic [31:0]       wbData;
  logic [CNT_W-1:0]  newCnt;
  logic              closeNow, sofEff, advance;
  logic [31:0]       statusWord;

  assign newCnt   = act.cnt + CNT_W'(1);
  assign closeNow = stb.accept && (sLast || newCnt == act.cap);
  assign sofEff   = act.sof || stb.markSof;
  assign advance  = closeNow || !act.valid;

  always_comb begin
    statusWord                = '0;
    statusWord[STAT_DONE_BIT] = 1'b1;
    statusWord[STAT_SOF_BIT]  = sofEff;
    statusWord[STAT_EOF_BIT]  = sLast;
    statusWord[CNT_W-1:0]     = newCnt;
  end

  always_comb begin
    fetched.valid   = 1'b1;
    fetched.desc    = stgDesc;
    fetched.bufBase = stgBuf;
    fetched.cap     = descRdata[CNT_W-1:0];
    fetched.cnt     = '0;
    fetched.sof     = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      act       <= '0;
      nxt       <= '0;
      fetchPtr  <= '0;
      tailPtr   <= '0;
      stgDesc   <= '0;
      stgNext   <= '0;
      stgBuf    <= '0;
      wbPending <= 1'b0;
      wbIrq     <= 1'b0;
      wbAddr    <= '0;
      wbData    <= '0;
      irqQ      <= 1'b0;
    end else begin
      // active buffer: hand over to the prefetched slot on close or when empty
      if (stb.loadCur)
        act.valid <= 1'b0;
      else if (advance)
        act <= nxt;
      else if (stb.accept) begin
        act.cnt <= newCnt;
        act.sof <= sofEff;
      end
      // prefetched slot
      if (stb.loadCur)
        nxt.valid <= 1'b0;
      else if (stb.fetchDone)
        nxt <= fetched;
      else if (advance)
        nxt.valid <= 1'b0;
      // pointers
      if (stb.loadCur)
        fetchPtr <= ptrData;
      else if (stb.fetchDone)
        fetchPtr <= stgNext;
      if (stb.loadTail) tailPtr <= ptrData;
      // fetch staging
      if (stb.fetchStart) stgDesc <= fetchPtr;
      if (stb.capWord && stb.capIdx == 2'd0) stgNext <= descRdata[ADDR_W-1:0];
      if (stb.capWord && stb.capIdx == 2'd1) stgBuf  <= descRdata[ADDR_W-1:0];
      // status write-back holding register
      if (closeNow) begin
        wbPending <= 1'b1;
        wbAddr    <= act.desc + ADDR_W'(OFF_STAT);
        wbData    <= statusWord;
        wbIrq     <= sLast;
      end else if (stb.wbFire) begin
        wbPending <= 1'b0;
      end
      irqQ <= stb.wbFire && wbIrq && irqEn;
    end
  end

  assign descReq   = stb.fetchIssue || stb.wbFire;
  assign descWe    = stb.wbFire;
  assign descAddr  = stb.wbFire ? wbAddr
                                : stgDesc + ADDR_W'({stb.fetchWord, 2'b00});
  assign descWdata = wbData;
  assign dataWe    = stb.accept;
  assign dataAddr  = act.bufBase + ADDR_W'(act.cnt);
  assign dataByte  = sData;
  assign irqDone   = irqQ;

  assign st.actValid  = act.valid;
  assign st.nxtValid  = nxt.valid;
  assign st.wbPending = wbPending;
  assign st.stgIsTail = (stgDesc == tailPtr);

  assert_irq_after_eof_wb_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqDone |-> $past(descWe && descWdata[STAT_EOF_BIT]));

  assert_count_below_cap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (act.valid && act.cap != '0) |-> act.cnt < act.cap);

  assert_consecutive_addr_R10: assert property (@(posedge clk) disable iff (!rstN)
    (dataWe && $past(dataWe) && !$past(closeNow)) |-> dataAddr == $past(dataAddr) + ADDR_W'(1));

  assert_prefetch_handover_R6: assert property (@(posedge clk) disable iff (!rstN)
    (closeNow && nxt.valid && !stb.loadCur) |=> st.actValid);

endmodule

// File: rtl/rxsg_splitter.sv
module rxsg_splitter
  import rxsg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runStop,
  input  logic              doneIrqEn,
  input  logic              curPtrWr,
  input  logic              tailPtrWr,
  input  logic [ADDR_W-1:0] ptrData,
  output logic              halted,
  output logic              idle,
  output logic              irqDone,
  input  logic              sValid,
  output logic              sReady,
  input  logic [7:0]        sData,
  input  logic              sLast,
  output logic              descReq,
  output logic              descWe,
  output logic [ADDR_W-1:0] descAddr,
  output logic [31:0]       descWdata,
  input  logic [31:0]       descRdata,
  output logic              dataWe,
  output logic [ADDR_W-1:0] dataAddr,
  output logic [7:0]        dataByte
);

  ctrlStrobe_t stb;
  dpStatus_t   st;

  rxsg_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .runStop   (runStop),
    .curPtrWr  (curPtrWr),
    .tailPtrWr (tailPtrWr),
    .sValid    (sValid),
    .sLast     (sLast),
    .st        (st),
    .stb       (stb),
    .halted    (halted),
    .idle      (idle),
    .sReady    (sReady)
  );

  rxsg_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .ptrData   (ptrData),
    .irqEn     (doneIrqEn),
    .sData     (sData),
    .sLast     (sLast),
    .descRdata (descRdata),
    .st        (st),
    .descReq   (descReq),
    .descWe    (descWe),
    .descAddr  (descAddr),
    .descWdata (descWdata),
    .dataWe    (dataWe),
    .dataAddr  (dataAddr),
    .dataByte  (dataByte),
    .irqDone   (irqDone)
  );

endmodule

// File: tb/rxsg_splitter_tb.sv
`timescale 1ns/1ps
module rxsg_splitter_tb_top;

  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              runStop = 1'b0, doneIrqEn = 1'b0;
  logic              curPtrWr = 1'b0, tailPtrWr = 1'b0;
  logic [ADDR_W-1:0] ptrData = '0;
  logic              halted, idle, irqDone;
  logic              sValid = 1'b0, sReady, sLast = 1'b0;
  logic [7:0]        sData = '0;
  logic              descReq, descWe, dataWe;
  logic [ADDR_W-1:0] descAddr, dataAddr;
  logic [31:0]       descWdata, descRdata;
  logic [7:0]        dataByte;

  always #10 clk = ~clk;

  rxsg_splitter #(.ADDR_W(ADDR_W), .CNT_W(16)) dut_i (
    .clk(clk), .rstN(rstN), .runStop(runStop), .doneIrqEn(doneIrqEn),
    .curPtrWr(curPtrWr), .tailPtrWr(tailPtrWr), .ptrData(ptrData),
    .halted(halted), .idle(idle), .irqDone(irqDone),
    .sValid(sValid), .sReady(sReady), .sData(sData), .sLast(sLast),
    .descReq(descReq), .descWe(descWe), .descAddr(descAddr),
    .descWdata(descWdata), .descRdata(descRdata),
    .dataWe(dataWe), .dataAddr(dataAddr), .dataByte(dataByte)
  );

  // memory model: 8 descriptors of 4 words, 8 buffers of 64 bytes at 0x1000
  logic [31:0] dmem [32];
  logic [7:0]  bmem [512];
  logic        ldWe = 1'b0, ldSel = 1'b0;
  logic [9:0]  ldA = '0;
  logic [31:0] ldD = '0;
  int          irqCnt, rdCnt;

  always @(posedge clk) begin
    if (ldWe) begin
      if (ldSel) bmem[ldA[8:0]] <= ldD[7:0];
      else       dmem[ldA[4:0]] <= ldD;
    end else begin
      if (descReq && descWe)  dmem[descAddr[6:2]] <= descWdata;
      if (descReq && !descWe) descRdata <= dmem[descAddr[6:2]];
      if (dataWe)             bmem[dataAddr[8:0]] <= dataByte;
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      irqCnt <= 0;
      rdCnt  <= 0;
    end else begin
      if (irqDone) irqCnt <= irqCnt + 1;
      if (descReq && !descWe) rdCnt <= rdCnt + 1;
    end
  end

  int nChecks = 0, nErr = 0, stalls = 0;
  int caps [8];
  logic [31:0] expStat [8];
  logic [7:0]  expByte [512];
  int mIdx, mCnt;
  bit mSof;

  task automatic chk(input string tag, input logic [31:0] actual, input logic [31:0] expected);
    nChecks++;
    if (actual !== expected) begin
      nErr++;
      $display("FAIL %s: actual=%h expected=%h", tag, actual, expected);
    end
  endtask

  // reference model of buffer filling
  task automatic mByte(input logic [7:0] d, input bit first, input bit last);
    logic [31:0] s;
    expByte[mIdx*64 + mCnt] = d;
    if (first) mSof = 1'b1;
    mCnt++;
    if (last || mCnt == caps[mIdx]) begin
      s = 32'h8000_0000;
      s[27] = mSof;
      s[26] = last;
      s[15:0] = mCnt[15:0];
      expStat[mIdx] = s;
      mIdx++;
      mCnt = 0;
      mSof = 1'b0;
    end
  endtask

  function automatic int needEnd(input int len);
    int idx = mIdx;
    int c = mCnt;
    for (int k = 0; k < len; k++) begin
      if (idx > 7) return 99;
      c++;
      if (c == caps[idx] || k == len - 1) begin
        idx++;
        c = 0;
      end
    end
    return idx;
  endfunction

  task automatic loadWord(input bit sel, input int a, input logic [31:0] d);
    @(negedge clk);
    ldWe = 1'b1; ldSel = sel; ldA = a[9:0]; ldD = d;
  endtask

  // hold reset, load the ring and clear buffers
  task automatic setupChain();
    rstN = 1'b0; runStop = 1'b0;
    for (int i = 0; i < 8; i++) begin
      loadWord(1'b0, i*4 + 0, ((i + 1) % 8) * 16);
      loadWord(1'b0, i*4 + 1, 32'h1000 + i * 64);
      loadWord(1'b0, i*4 + 2, caps[i]);
      loadWord(1'b0, i*4 + 3, 32'h0);
      expStat[i] = 32'h0;
    end
    for (int j = 0; j < 512; j++) begin
      loadWord(1'b1, j, 32'h0);
      expByte[j] = 8'h0;
    end
    @(negedge clk);
    ldWe = 1'b0;
    mIdx = 0; mCnt = 0; mSof = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writePtr(input bit tail, input logic [31:0] v);
    @(negedge clk);
    ptrData = v;
    if (tail) tailPtrWr = 1'b1; else curPtrWr = 1'b1;
    @(negedge clk);
    tailPtrWr = 1'b0; curPtrWr = 1'b0;
  endtask

  task automatic startRun(input int tailIdx);
    writePtr(1'b0, 32'h0);
    @(negedge clk); runStop = 1'b1;
    @(negedge clk);
    writePtr(1'b1, tailIdx * 16);
    repeat (20) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] d, input bit l, output bit ok, output int w);
    ok = 1'b0; w = 0;
    @(negedge clk);
    sValid = 1'b1; sData = d; sLast = l;
    while (!sReady && w < 40) begin
      @(negedge clk);
      w++;
    end
    if (sReady) begin
      @(posedge clk);
      ok = 1'b1;
    end
    #1 sValid = 1'b0;
  endtask

  task automatic sendRange(input int total, input int from, input bit gapless, output int sent);
    bit ok; int w; logic [7:0] d;
    sent = 0;
    for (int k = from; k < total; k++) begin
      if (!gapless) repeat ($urandom % 3) @(negedge clk);
      d = 8'($urandom);
      sendByte(d, k == total - 1, ok, w);
      if (!ok) break;
      if (gapless && k > from) stalls += w;
      mByte(d, k == 0, k == total - 1);
      sent++;
    end
  endtask

  task automatic checkChain(input string tag);
    int cnt, mism;
    for (int i = 0; i < 8; i++) begin
      chk({tag, " R1 R3 R4 R11 status"}, dmem[i*4 + 3], expStat[i]);
      cnt = int'(expStat[i][15:0]);
      mism = 0;
      for (int j = 0; j < cnt; j++)
        if (bmem[i*64 + j] !== expByte[i*64 + j]) mism++;
      if (cnt > 0) chk({tag, " R2 R10 buffer bytes"}, mism, 0);
    end
  endtask

  initial begin
    #(20ns * 150000);
    nErr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    int sent;
    void'($urandom(32'd20240611));

    // ---------- reset state and arming (R7, R11, R6) ----------
    for (int i = 0; i < 8; i++) caps[i] = 8;
    setupChain();
    @(negedge clk);
    chk("R7 reset halted", halted, 1);
    chk("R7 reset sReady", sReady, 0);
    chk("R7 reset idle", idle, 0);
    chk("R9 reset irqDone", irqDone, 0);
    chk("R7 reset descReq", descReq, 0);
    writePtr(1'b1, 32'h70);          // ignored: run/stop is 0
    repeat (10) @(negedge clk);
    chk("R7 tail load while stopped ignored", rdCnt, 0);
    writePtr(1'b0, 32'h0);
    @(negedge clk); runStop = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R7 halted cleared", halted, 0);
    repeat (10) @(negedge clk);
    chk("R7 no fetch before tail load", rdCnt, 0);
    writePtr(1'b1, 32'h70);
    repeat (20) @(negedge clk);
    chk("R6 R11 one descriptor ahead (reads)", rdCnt, 6);

    // ---------- directed packets, gapless (R5, R6, R9) ----------
    doneIrqEn = 1'b1;
    stalls = 0;
    sendRange(3, 0, 1'b1, sent);
    sendRange(8, 0, 1'b1, sent);
    sendRange(20, 0, 1'b1, sent);
    repeat (10) @(negedge clk);
    chk("R5 single buffer flags", dmem[3][27:26], 2'b11);
    chk("R6 no stall on buffer change", stalls, 0);
    chk("R9 one irq per packet", irqCnt, 3);
    checkChain("directed");

    // ---------- random capacities and gaps, irq disabled (R2, R4, R9) ----------
    for (int i = 0; i < 8; i++) caps[i] = 1 + ($urandom % 16);
    caps[1] = 1;
    setupChain();
    doneIrqEn = 1'b0;
    startRun(7);
    for (int p = 0; p < 30; p++) begin
      int len;
      len = 1 + ($urandom % 24);
      if (needEnd(len) > 8) begin
        len = 1;
        if (needEnd(len) > 8) break;
      end
      sendRange(len, 0, 1'b0, sent);
    end
    repeat (10) @(negedge clk);
    chk("R9 no irq when disabled", irqCnt, 0);
    checkChain("random");

    // ---------- tail exhaustion mid-packet (R8), then tail moved (R2, R3) ----------
    for (int i = 0; i < 8; i++) caps[i] = 4;
    setupChain();
    doneIrqEn = 1'b1;
    startRun(1);
    sendRange(12, 0, 1'b0, sent);
    repeat (5) @(negedge clk);
    chk("R8 bytes taken before stall", sent, 8);
    chk("R8 ready low at exhaustion", sReady, 0);
    chk("R8 idle set at exhaustion", idle, 1);
    chk("R9 no irq without end-of-packet", irqCnt, 0);
    checkChain("exhaust");
    writePtr(1'b1, 32'h30);
    sendRange(12, 8, 1'b0, sent);
    repeat (10) @(negedge clk);
    chk("R2 rest of packet after tail move", sent, 4);
    chk("R3 continuation closes with end flag", dmem[2*4 + 3], 32'h8400_0004);
    chk("R9 irq after packet end", irqCnt, 1);
    chk("R8 idle clear after tail move", idle, 0);
    checkChain("resume");

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule